// File: doc/BRIEF.md
# Lock-Gated System Clock Selector

This block holds an eight-bit clock-control register and turns its contents into the controls that choose the system clock source. Software reads and writes the register through a plain single-cycle port. The block watches the PLL lock status, three low-power mode levels (stop, wait, self-clock) and a static oscillator-configuration pin. From these it drives gate enables for the oscillator and PLL clock paths, an enable that keeps the oscillator running through stop mode, a PLL power-down request, and a clock enable that runs the bus at half the rate of the selected source.

Selecting the PLL is guarded: a request to switch to the PLL is refused while the synchronized lock status is low, and hardware drops the selection when the chip enters stop mode, self-clock mode, or wait mode with the PLL-off-in-wait option set. The read value always shows the selection actually in force, so software can read back and confirm a switch. Source changes pass through a two-step handshake that turns the old gate off one cycle before the new gate turns on.

The register port has no back-pressure: a write is taken on the clock edge where `wr_en` is high, and `rd_data` reflects the register at all times.

Top module: `clksel_ctrl`

## Requirements
- R1: After reset the register reads 0 in every bit except bit 5, which shows `osc_cfg`; `osc_gate_en` is 1, `pll_gate_en` is 0.
- R2: Register layout: bit 7 PLL select, bit 6 oscillator-keep-in-stop, bit 5 oscillator configuration (read-only), bit 3 PLL-off-in-wait, bits 1 and 0 two plain stored flags; bits 4 and 2 always read 0 and ignore writes. Bits 6, 3, 1, 0 take the written value on any write.
- R3: A write with bit 7 set while the synchronized lock is 0 leaves bit 7 unchanged; a write with bit 7 clear always clears it.
- R4: The lock input passes through a two-flop synchronizer: writes captured on the first two rising edges after lock rises are still refused, the third is accepted.
- R5: Bit 7 is cleared on the edge where stop or self-clock goes from 0 to 1, and where wait goes from 0 to 1 while bit 3 is set; wait entry with bit 3 clear keeps it. Such a clear wins over a write in the same cycle, and a later write may set it again while the mode stays high.
- R6: A fall of lock while bit 7 is 1 does not change bit 7 or the selected source.
- R7: One edge after bit 7 changes, the enable of the old source goes to 0; one edge later the enable of the new source goes to 1. The two enables are never 1 together.
- R8: `bus_clk_en` toggles on every edge while a source enable is 1 and holds its value while both are 0.
- R9: `osc_keep_run` equals bit 6; `pll_pwrdn` is 1 while `wait_mode` is 1 and bit 3 is set.
- R10: Writes do not change bit 5; it follows `osc_cfg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read value |
| pll_lock | input | 1 | PLL lock status, asynchronous |
| stop_mode | input | 1 | Stop mode active level |
| wait_mode | input | 1 | Wait mode active level |
| selfclk_mode | input | 1 | Self-clock mode active level |
| osc_cfg | input | 1 | Oscillator configuration (0 loop-controlled, 1 external/full swing) |
| osc_gate_en | output | 1 | Gate enable for the oscillator clock path |
| pll_gate_en | output | 1 | Gate enable for the PLL clock path |
| bus_clk_en | output | 1 | Divide-by-two bus clock enable |
| osc_keep_run | output | 1 | Keep oscillator running in stop mode |
| pll_pwrdn | output | 1 | PLL power-down request |

## Verification
The two functions that can collide are a software write setting the PLL select bit and a hardware clear from mode entry landing on the same edge. The bench drives a write of bit 7 together with the rising edge of stop mode in one cycle and expects the bit to read 0 afterwards, then repeats the write with the mode still high and expects it to stick. A second collision, a select write in the cycles just after lock rises, is judged edge by edge against the synchronizer depth.

// File: rtl/clksel_pkg.sv
package clksel_pkg;
  localparam int unsigned REG_W    = 8;
  localparam int unsigned B_PLLSEL = 7;
  localparam int unsigned B_KEEP   = 6;
  localparam int unsigned B_CFG    = 5;
  localparam int unsigned B_PLLOFF = 3;
  localparam int unsigned B_FLAG1  = 1;
  localparam int unsigned B_FLAG0  = 0;

  typedef enum logic [1:0] {
    SW_OSC    = 2'd0,
    SW_TO_PLL = 2'd1,
    SW_PLL    = 2'd2,
    SW_TO_OSC = 2'd3
  } sw_state_t;
endpackage

// File: rtl/clksel_sync.sv
module clksel_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '0;
        else        chain <= d;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/clksel_regs.sv
module clksel_regs
  import clksel_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             lock_s,
  input  logic             stop_mode,
  input  logic             wait_mode,
  input  logic             selfclk_mode,
  input  logic             osc_cfg,
  output logic [REG_W-1:0] rd_data,
  output logic             pll_sel,
  output logic             keep_run,
  output logic             pll_off_wait
);
  logic flag1, flag0;
  logic stop_q, wait_q, self_q;
  logic stop_entry, wait_entry, self_entry, hw_clear;
  logic unused_wr_bits;

  assign unused_wr_bits = ^{wr_data[B_CFG], wr_data[4], wr_data[2]};

  assign stop_entry = stop_mode    & ~stop_q;
  assign wait_entry = wait_mode    & ~wait_q;
  assign self_entry = selfclk_mode & ~self_q;
  assign hw_clear   = stop_entry | self_entry | (wait_entry & pll_off_wait);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_q       <= 1'b0;
      wait_q       <= 1'b0;
      self_q       <= 1'b0;
      pll_sel      <= 1'b0;
      keep_run     <= 1'b0;
      pll_off_wait <= 1'b0;
      flag1        <= 1'b0;
      flag0        <= 1'b0;
    end else begin
      stop_q <= stop_mode;
      wait_q <= wait_mode;
      self_q <= selfclk_mode;
      if (wr_en) begin
        keep_run     <= wr_data[B_KEEP];
        pll_off_wait <= wr_data[B_PLLOFF];
        flag1        <= wr_data[B_FLAG1];
        flag0        <= wr_data[B_FLAG0];
      end
      if (hw_clear)
        pll_sel <= 1'b0;
      else if (wr_en && (!wr_data[B_PLLSEL] || lock_s))
        pll_sel <= wr_data[B_PLLSEL];
    end
  end

  always_comb begin
    rd_data           = '0;
    rd_data[B_PLLSEL] = pll_sel;
    rd_data[B_KEEP]   = keep_run;
    rd_data[B_CFG]    = osc_cfg;
    rd_data[B_PLLOFF] = pll_off_wait;
    rd_data[B_FLAG1]  = flag1;
    rd_data[B_FLAG0]  = flag0;
  end
endmodule

// File: rtl/clksel_switch.sv
module clksel_switch
  import clksel_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic want_pll,
  output logic osc_gate_en,
  output logic pll_gate_en,
  output logic bus_clk_en
);
  sw_state_t state, state_nx;

  always_comb begin
    state_nx = state;
    unique case (state)
      SW_OSC:    if (want_pll)  state_nx = SW_TO_PLL;
      SW_TO_PLL: state_nx = SW_PLL;
      SW_PLL:    if (!want_pll) state_nx = SW_TO_OSC;
      SW_TO_OSC: state_nx = SW_OSC;
      default:   state_nx = SW_OSC;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= SW_OSC;
      bus_clk_en <= 1'b0;
    end else begin
      state <= state_nx;
      if (osc_gate_en || pll_gate_en)
        bus_clk_en <= ~bus_clk_en;
    end
  end

  assign osc_gate_en = (state == SW_OSC);
  assign pll_gate_en = (state == SW_PLL);
endmodule

// File: rtl/clksel_ctrl.sv
module clksel_ctrl #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       pll_lock,
  input  logic       stop_mode,
  input  logic       wait_mode,
  input  logic       selfclk_mode,
  input  logic       osc_cfg,
  output logic       osc_gate_en,
  output logic       pll_gate_en,
  output logic       bus_clk_en,
  output logic       osc_keep_run,
  output logic       pll_pwrdn
);
  logic lock_s;
  logic pll_sel;
  logic pll_off_wait;

  clksel_sync #(.STAGES(SYNC_STAGES)) u_lock_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pll_lock),
    .q     (lock_s)
  );

  clksel_regs u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .lock_s       (lock_s),
    .stop_mode    (stop_mode),
    .wait_mode    (wait_mode),
    .selfclk_mode (selfclk_mode),
    .osc_cfg      (osc_cfg),
    .rd_data      (rd_data),
    .pll_sel      (pll_sel),
    .keep_run     (osc_keep_run),
    .pll_off_wait (pll_off_wait)
  );

  clksel_switch u_switch (
    .clk         (clk),
    .rst_n       (rst_n),
    .want_pll    (pll_sel),
    .osc_gate_en (osc_gate_en),
    .pll_gate_en (pll_gate_en),
    .bus_clk_en  (bus_clk_en)
  );

  assign pll_pwrdn = wait_mode & pll_off_wait;
endmodule

// File: rtl/clksel_ctrl_chk.sv
module clksel_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       lock_s,
  input logic       stop_mode,
  input logic       selfclk_mode,
  input logic       osc_gate_en,
  input logic       pll_gate_en,
  input logic       bus_clk_en
);
  a_r7_never_both: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({osc_gate_en, pll_gate_en}));

  a_r7_break_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_gate_en) |-> $past(!osc_gate_en));

  a_r7_break_first_osc: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(osc_gate_en) |-> $past(!pll_gate_en));

  a_r3_refuse_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[7] && !lock_s && !rd_data[7]) |=> !rd_data[7]);

  a_r5_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_mode) |=> !rd_data[7]);

  a_r5_selfclk_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(selfclk_mode) |=> !rd_data[7]);

  a_r8_hold_in_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_gate_en && !pll_gate_en) |=> $stable(bus_clk_en));

  a_r8_toggle_live: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_gate_en || pll_gate_en) |=> (bus_clk_en != $past(bus_clk_en)));
endmodule

bind clksel_ctrl clksel_ctrl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_en        (wr_en),
  .wr_data      (wr_data),
  .rd_data      (rd_data),
  .lock_s       (lock_s),
  .stop_mode    (stop_mode),
  .selfclk_mode (selfclk_mode),
  .osc_gate_en  (osc_gate_en),
  .pll_gate_en  (pll_gate_en),
  .bus_clk_en   (bus_clk_en)
);

// File: tb/clksel_ctrl_tb.sv
module clksel_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       pll_lock = 1'b0;
  logic       stop_mode = 1'b0;
  logic       wait_mode = 1'b0;
  logic       selfclk_mode = 1'b0;
  logic       osc_cfg = 1'b1;
  logic       osc_gate_en, pll_gate_en, bus_clk_en, osc_keep_run, pll_pwrdn;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    string      tag;
    logic [7:0] exp;
  } rd_item_t;
  rd_item_t sb_q[$];

  always #2 clk = ~clk;

  clksel_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .pll_lock(pll_lock), .stop_mode(stop_mode), .wait_mode(wait_mode),
    .selfclk_mode(selfclk_mode), .osc_cfg(osc_cfg), .osc_gate_en(osc_gate_en),
    .pll_gate_en(pll_gate_en), .bus_clk_en(bus_clk_en),
    .osc_keep_run(osc_keep_run), .pll_pwrdn(pll_pwrdn)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // driver side: expected read value enters the scoreboard
  task automatic expect_rd(input string tag, input logic [7:0] exp);
    rd_item_t it;
    it.tag = tag;
    it.exp = exp;
    sb_q.push_back(it);
    #1;
  endtask

  // monitor: pops items and compares against the port
  initial begin
    forever begin
      wait (sb_q.size() > 0);
      #0.5;
      begin
        rd_item_t it;
        it = sb_q.pop_front();
        chk(it.tag, rd_data, it.exp);
      end
    end
  end

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #400000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic b0, b1;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    expect_rd("R1 reset value", 8'h20);
    chk("R1 osc gate after reset", {7'd0, osc_gate_en}, 8'h01);
    chk("R1 pll gate after reset", {7'd0, pll_gate_en}, 8'h00);

    b0 = bus_clk_en;
    @(negedge clk);
    chk("R8 bus enable toggles", {7'd0, bus_clk_en}, {7'd0, ~b0});

    // unlocked write of all ones
    wr(8'hFF);
    expect_rd("R2 R3 layout and refusal", 8'h6B);
    wr(8'h00);
    expect_rd("R10 cfg bit kept by write", 8'h20);
    osc_cfg = 1'b0;
    #0.1;
    expect_rd("R10 cfg bit follows pin", 8'h00);

    wr(8'h40);
    chk("R9 keep-run follows bit 6", {7'd0, osc_keep_run}, 8'h01);
    wr(8'h08);
    chk("R9 no powerdown outside wait", {7'd0, pll_pwrdn}, 8'h00);
    wait_mode = 1'b1;
    #0.1;
    chk("R9 powerdown in wait", {7'd0, pll_pwrdn}, 8'h01);
    @(negedge clk);
    wait_mode = 1'b0;
    wr(8'h00);

    // lock rises: synchronizer depth
    @(negedge clk);
    pll_lock = 1'b1;
    wr_en = 1'b1;
    wr_data = 8'h80;
    @(negedge clk);
    expect_rd("R4 refused at first edge", 8'h00);
    @(negedge clk);
    expect_rd("R4 refused at second edge", 8'h00);
    @(negedge clk);
    wr_en = 1'b0;
    expect_rd("R4 accepted at third edge", 8'h80);
    chk("R7 old source still on", {6'd0, osc_gate_en, pll_gate_en}, 8'h02);
    @(negedge clk);
    chk("R7 gap with both off", {6'd0, osc_gate_en, pll_gate_en}, 8'h00);
    b1 = bus_clk_en;
    @(negedge clk);
    chk("R7 new source on", {6'd0, osc_gate_en, pll_gate_en}, 8'h01);
    chk("R8 bus enable held in gap", {7'd0, bus_clk_en}, {7'd0, b1});

    // lock lost while selected
    pll_lock = 1'b0;
    idle(4);
    expect_rd("R6 select kept after lock loss", 8'h80);
    chk("R6 pll gate kept", {7'd0, pll_gate_en}, 8'h01);

    pll_lock = 1'b1;
    idle(3);
    // collision: write and stop entry on the same edge
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = 8'h80;
    stop_mode = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    expect_rd("R5 stop entry beats write", 8'h00);
    wr(8'h80);
    expect_rd("R5 rewrite while stop held", 8'h80);
    stop_mode = 1'b0;

    @(negedge clk);
    selfclk_mode = 1'b1;
    @(negedge clk);
    expect_rd("R5 selfclk entry clears", 8'h00);
    idle(3);
    chk("R7 back on oscillator", {6'd0, osc_gate_en, pll_gate_en}, 8'h02);
    selfclk_mode = 1'b0;

    wr(8'h80);
    wait_mode = 1'b1;
    @(negedge clk);
    expect_rd("R5 wait entry without pll-off keeps", 8'h80);
    wait_mode = 1'b0;
    wr(8'h88);
    expect_rd("R5 select with pll-off", 8'h88);
    wait_mode = 1'b1;
    @(negedge clk);
    expect_rd("R5 wait entry with pll-off clears", 8'h08);
    wait_mode = 1'b0;
    wr(8'h88);
    expect_rd("R5 software reselect after wait", 8'h88);

    idle(2);
    wait (sb_q.size() == 0);
    idle(1);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule